// File: doc/BRIEF.md
# Bit-Sliced ALU with Status Flags

This block is a purely combinational arithmetic and logic unit of parameterised width (four bits by default). It takes two operands and a two-bit operation code and returns a result word together with three status flags: carry-out, signed overflow and zero. There is no clock and no storage inside it. The outputs follow the inputs after the propagation delay of the carry chain.

The datapath is a ripple chain of identical one-bit slices. Each slice holds a full adder, an AND/OR logic path and a select. Subtraction uses the same adders: every b bit is inverted and a carry of one is injected into the lowest slice. The carry leaving the top slice therefore means "no borrow". A small flag stage gates carry and overflow to zero in the logic modes and derives the zero flag from the result in every mode.

Top module: `alu_sliced`

## Requirements
- R1: Operation code 2'b00 drives each result bit to the AND of the matching operand bits.
- R2: Operation code 2'b01 drives each result bit to the OR of the matching operand bits.
- R3: Operation code 2'b10 drives the result to the low WIDTH bits of a + b. Carry-out is bit WIDTH of that unsigned sum, so 1111 + 0111 gives 0110 with carry 1.
- R4: Operation code 2'b11 drives the result to a + NOT b + 1, truncated to WIDTH bits. Carry-out is 1 exactly when no borrow occurs (a >= b unsigned), so 0000 - 0000 gives carry 1 and 1000 - 1111 gives 1001 with carry 0.
- R5: In add mode, overflow is 1 exactly when the true signed sum of the two's-complement operands lies outside the signed WIDTH-bit range. For example, 0111 + 0001 gives overflow 1, and 1000 + 1111 gives 0111 with overflow 1.
- R6: In subtract mode, overflow is 1 exactly when the true signed difference lies outside the signed WIDTH-bit range. For example, 0111 - 1111 and 1000 - 0001 give overflow 1, while 1111 - 0111 gives overflow 0.
- R7: In both logic modes (op bit 1 equal to 0), carry-out and overflow are 0 for every operand pair.
- R8: The zero flag is 1 exactly when every result bit is 0, in all four modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| op_i | input | 2 | Operation code: 00 AND, 01 OR, 10 add, 11 subtract |
| res_o | output | WIDTH | Result word |
| carry_o | output | 1 | Carry-out of the top slice; 0 in logic modes |
| ovf_o | output | 1 | Two's-complement overflow; 0 in logic modes |
| zero_o | output | 1 | 1 when the result is all zeros |

## Verification
The assertions assume that the operands and the operation code hold known values. They are skipped whenever any input bit is X or Z, because a combinational block gives no defined answer on such inputs. The bench meets this assumption by driving every input from time zero, before anything is sampled. It walks every operand pair under every operation code, then adds seeded random pairs and the signed-boundary cases named in the requirements. Each output is compared with a reference that computes the sums in wider integers.

// File: rtl/alu_pkg.sv
// Package: shared operation encoding for the sliced ALU.
// Assumes: the two-bit code is decoded identically by every slice and the flag stage.
package alu_pkg;
    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_full_add.sv
// Module: one-bit full adder used inside each slice.
// Assumes: purely combinational, no state.
module alu_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic prop;
    // Propagate term, sum and generate/propagate carry.
    always_comb begin
        prop = x_i ^ y_i;
        s_o  = prop ^ c_i;
        c_o  = (x_i & y_i) | (c_i & prop);
    end
endmodule

// File: rtl/alu_bit_slice.sv
// Module: one bit of the ALU, made of an adder, a logic path and a result select.
// Assumes: sub_i is 1 only for subtract. It conditionally inverts the b bit on the adder path.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    cin_i,
    input  logic    sub_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    cout_o
);
    logic b_eff;
    logic sum_bit;

    // Invert b for subtraction before it reaches the adder.
    always_comb b_eff = b_i ^ sub_i;

    alu_full_add fa_i (
        .x_i (a_i),
        .y_i (b_eff),
        .c_i (cin_i),
        .s_o (sum_bit),
        .c_o (cout_o)
    );

    // Pick the slice output for the selected operation.
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            default: res_o = sum_bit;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
// Module: derives the carry, overflow and zero flags from the slice chain.
// Assumes: c_top_in is the carry entering the top slice and c_top_out the carry leaving it.
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  alu_op_e          op_i,
    input  logic             c_top_in,
    input  logic             c_top_out,
    input  logic [WIDTH-1:0] res_i,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);
    logic arith;

    // Gate carry and overflow to the arithmetic modes; derive zero in all modes.
    always_comb begin
        arith   = (op_i == OP_ADD) || (op_i == OP_SUB);
        carry_o = arith & c_top_out;
        ovf_o   = arith & (c_top_in ^ c_top_out);
        zero_o  = ~|res_i;
    end
endmodule

// File: rtl/alu_sliced.sv
// Module: top of the combinational ALU, a ripple chain of WIDTH slices plus flags.
// Assumes: WIDTH >= 2, so that the carry into the top slice is distinct from the chain input.
module alu_sliced
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic             sub;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] res;

    // Decode the code; subtract is the only mode that injects a carry.
    always_comb begin
        op       = alu_op_e'(op_i);
        sub      = op_i[1] & op_i[0];
        chain[0] = sub;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice slice_i (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .cin_i  (chain[i]),
            .sub_i  (sub),
            .op_i   (op),
            .res_o  (res[i]),
            .cout_o (chain[i+1])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) flags_i (
        .op_i      (op),
        .c_top_in  (chain[MSB]),
        .c_top_out (chain[WIDTH]),
        .res_i     (res),
        .carry_o   (carry_o),
        .ovf_o     (ovf_o),
        .zero_o    (zero_o)
    );

    // Drive the result port.
    always_comb res_o = res;
endmodule

// File: rtl/alu_sliced_chk.sv
// Checker: port-level properties of the ALU, evaluated whenever the inputs are known.
// Assumes: inputs free of X/Z; checks are skipped otherwise.
module alu_sliced_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] res_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             zero_o
);
    localparam int MSB = WIDTH - 1;
    logic [WIDTH:0] wide_add;
    logic [WIDTH:0] wide_sub;

    // Compare the outputs with wide arithmetic for each mode.
    always_comb begin
        wide_add = {1'b0, a_i} + {1'b0, b_i};
        wide_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op_i == 2'b00) AST_AND_RESULT: assert (res_o == (a_i & b_i)); // R1
            if (op_i == 2'b01) AST_OR_RESULT: assert (res_o == (a_i | b_i)); // R2
            if (op_i == 2'b10) AST_ADD_SUM: assert ({carry_o, res_o} == wide_add); // R3
            if (op_i == 2'b11) AST_SUB_DIFF: assert ({carry_o, res_o} == wide_sub); // R4
            if (op_i == 2'b10) AST_ADD_OVF: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]))); // R5
            if (op_i == 2'b11) AST_SUB_OVF: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]))); // R6
            if (!op_i[1]) AST_NO_CARRY: assert (!carry_o); // R7
            if (!op_i[1]) AST_NO_OVERFLOW: assert (!ovf_o); // R7
            AST_ZERO_FLAG: assert (zero_o == (res_o == '0)); // R8
        end
    end
endmodule

bind alu_sliced alu_sliced_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o)
);

// File: tb/alu_sliced_tb_top.sv
module alu_sliced_tb_top;
    localparam int W    = 4;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] res;
    logic carry, ovf, zero;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu_sliced #(.WIDTH(W)) dut_i (
        .a_i(a), .b_i(b), .op_i(op),
        .res_o(res), .carry_o(carry), .ovf_o(ovf), .zero_o(zero)
    );

    function automatic int sval(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    function automatic logic [W-1:0] exp_res(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o);
        int u;
        case (o)
            2'b00: return x & y;
            2'b01: return x | y;
            2'b10: begin u = int'(x) + int'(y); return u[W-1:0]; end
            default: begin u = int'(x) - int'(y) + (1 << W); return u[W-1:0]; end
        endcase
    endfunction

    function automatic logic exp_carry(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o);
        case (o)
            2'b10: return (int'(x) + int'(y)) >= (1 << W);
            2'b11: return int'(x) >= int'(y);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o);
        int s;
        case (o)
            2'b10: s = sval(x) + sval(y);
            2'b11: s = sval(x) - sval(y);
            default: return 1'b0;
        endcase
        return (s > SMAX) || (s < SMIN);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: a=%b b=%b op=%b actual=%0h expected=%0h", req, what, a, b, op, act, exp);
        end
    endtask

    // Drive on the falling edge, let the logic settle, then compare every output.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o);
        logic [W-1:0] er;
        @(negedge clk);
        a = x; b = y; op = o;
        #2;
        er = exp_res(x, y, o);
        case (o)
            2'b00: chk("R1", "and result", int'(res), int'(er));
            2'b01: chk("R2", "or result", int'(res), int'(er));
            2'b10: chk("R3", "add result", int'(res), int'(er));
            default: chk("R4", "sub result", int'(res), int'(er));
        endcase
        if (o[1]) begin
            chk(o[0] ? "R4" : "R3", "carry", int'(carry), int'(exp_carry(x, y, o)));
            chk(o[0] ? "R6" : "R5", "overflow", int'(ovf), int'(exp_ovf(x, y, o)));
        end else begin
            chk("R7", "logic carry", int'(carry), 0);
            chk("R7", "logic overflow", int'(ovf), 0);
        end
        chk("R8", "zero", int'(zero), int'(er == '0));
    endtask

    // Directed case with explicit expected values from the requirements.
    task automatic fixed(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] o,
                         input logic [W-1:0] r, input logic c, input logic v, input logic z);
        @(negedge clk);
        a = x; b = y; op = o;
        #2;
        chk(req, "directed result", int'(res), int'(r));
        chk(req, "directed carry", int'(carry), int'(c));
        chk(req, "directed overflow", int'(ovf), int'(v));
        chk(req, "directed zero", int'(zero), int'(z));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs select AND of zeros.
        #1;
        chk("R8", "idle zero", int'(zero), 1);
        chk("R7", "idle carry", int'(carry), 0);
        // Directed corners, R1..R8.
        fixed("R8", 4'b1000, 4'b0001, 2'b00, 4'b0000, 0, 0, 1);
        fixed("R2", 4'b1000, 4'b0001, 2'b01, 4'b1001, 0, 0, 0);
        fixed("R5", 4'b0111, 4'b0001, 2'b10, 4'b1000, 0, 1, 0);
        fixed("R5", 4'b1000, 4'b1111, 2'b10, 4'b0111, 1, 1, 0);
        fixed("R3", 4'b1111, 4'b0111, 2'b10, 4'b0110, 1, 0, 0);
        fixed("R4", 4'b0000, 4'b0000, 2'b11, 4'b0000, 1, 0, 1);
        fixed("R4", 4'b1000, 4'b1111, 2'b11, 4'b1001, 0, 0, 0);
        fixed("R6", 4'b0111, 4'b1111, 2'b11, 4'b1000, 0, 1, 0);
        fixed("R6", 4'b1000, 4'b0001, 2'b11, 4'b0111, 1, 1, 0);
        fixed("R6", 4'b1111, 4'b0111, 2'b11, 4'b1000, 1, 0, 0);
        fixed("R7", 4'b1111, 4'b1111, 2'b00, 4'b1111, 0, 0, 0);
        fixed("R1", 4'b0111, 4'b1111, 2'b00, 4'b0111, 0, 0, 0);
        // Every operand pair under every code.
        for (int o = 0; o < 4; o++)
            for (int x = 0; x < (1 << W); x++)
                for (int y = 0; y < (1 << W); y++)
                    apply(W'(x), W'(y), 2'(o));
        // Seeded random mix.
        for (int k = 0; k < 500; k++)
            apply(W'($urandom), W'($urandom), 2'($urandom));
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule